// File: doc/BRIEF.md
# Adaptive Assist Buffer Allocator

This block shares one pool of small line buffers among the cache-assist mechanisms that sit between the first- and second-level caches. There are three mechanisms: stride prefetch (index 0), victim buffer (index 1) and write buffer (index 2). Each mechanism feeds per-cycle event strobes into its own monitor: miss, hit, stall, and "all my buffers are full". The monitors count these events over a fixed observation interval. At the interval boundary the allocator decides the buffer split and the prefetch lookahead that apply for the whole next interval.

In automatic mode, at most one buffer moves per boundary. It goes from the mechanism that benefits least to the one that benefits most, and only when the gap between them exceeds a hysteresis margin. Lookahead grows for a mechanism that stalled while its buffers were full, and shrinks when it did not stall at all. Software can write a full split through a small configuration port. The split is applied at the next boundary and freezes automatic reallocation until software releases it. Software also sees the same miss, hit and stall figures that the allocator used at the last boundary.

The outputs are a per-mechanism buffer count, a buffer-ownership map, a per-mechanism lookahead and the readback counts. The buffer datapaths that act on the map are outside this block.

Top module: `aba_buffer_allocator`

## Requirements
- R1: While reset is active and until the first boundary, the split is 4/2/2 for mechanisms 0/1/2: each mechanism gets POOL/3 buffers and mechanism 0 also takes the remainder. Every lookahead is 1, every readback count is 0 and `interval_end_o` is low.
- R2: `interval_end_o` is high for exactly one cycle in every INTERVAL (256) cycles. The first time it is high is the 256th cycle after the internal reset synchronizer lets go.
- R3: In every cycle the three counts sum to the pool size (8), and each count is at least 1.
- R4: Ownership is contiguous and in index order. Buffer b (field `own_map_o[2b+1:2b]`) holds the owner code m, equal to the mechanism index, when a0+…+a(m-1) ≤ b < a0+…+am.
- R5: In automatic mode, each mechanism has a score at the boundary equal to its hits minus (stalls >> 1). The receiver is the mechanism with the highest score; on a tie the lowest index wins. The donor is the mechanism with the lowest score among those holding more than 1 buffer; on a tie the lowest index wins. Exactly one buffer moves from donor to receiver when both exist, they differ, and receiver score minus donor score is greater than 8. Otherwise the split is unchanged. Counts change only on the clock edge that ends a boundary cycle.
- R6: Monitor counts are 7 bits wide and saturate at 127 instead of wrapping. Events that arrive in the boundary cycle are discarded, and counting restarts from 0 in the next interval.
- R7: On the boundary edge, `rd_miss_o`, `rd_hit_o` and `rd_stall_o` (7 bits per mechanism, mechanism m at bits [7m+6:7m]) take the counts of the interval just ended. They hold those values until the next boundary.
- R8: Lookahead (3 bits, range 1..4) changes only at a boundary. It rises by 1 if the mechanism saw at least 4 cycles with full and stall both high, and it is not already 4. Otherwise it falls by 1 if the mechanism had no stall cycles, and it is not already 1. Otherwise it holds.
- R9: A write with `cfg_hold_i`=1 carries mechanism m's count in `cfg_alloc_i[4m+3:4m]`. If every count is nonzero and the counts sum to 8, the write sets manual mode and the split appears at the next boundary. Automatic moves then stop. A write whose counts are zero or do not sum to 8 is ignored entirely.
- R10: A write with `cfg_hold_i`=0 leaves manual mode and drops any split still pending. Automatic moves resume at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| ev_miss_i | input | 3 | Per-mechanism miss strobe |
| ev_hit_i | input | 3 | Per-mechanism hit strobe |
| ev_stall_i | input | 3 | Per-mechanism processor stall strobe |
| ev_full_i | input | 3 | Per-mechanism all-buffers-occupied flag |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_hold_i | input | 1 | 1: load the split and hold it; 0: release to automatic mode |
| cfg_alloc_i | input | 12 | Requested counts, 4 bits per mechanism |
| interval_end_o | output | 1 | High during the last cycle of each interval |
| alloc_cnt_o | output | 12 | Current buffer count per mechanism, 4 bits each |
| own_map_o | output | 16 | Owner code per buffer, 2 bits each |
| lookahead_o | output | 9 | Prefetch lookahead per mechanism, 3 bits each |
| rd_miss_o | output | 21 | Misses of the last completed interval |
| rd_hit_o | output | 21 | Hits of the last completed interval |
| rd_stall_o | output | 21 | Stall cycles of the last completed interval |

## Verification
The hardest condition to reach is donor exhaustion. In that state every mechanism except the favourite sits at the 1-buffer floor, so the only legal donor is the receiver itself, and the allocator must hold the split even though the scores stay far apart. The bench gets there with several intervals of biased stimulus: all hits go to mechanism 2 while the other two only stall, which drains them one buffer per boundary. The bench then applies saturation, lookahead and manual-mode phases, and finishes with random events that include occasional random configuration writes, some of which land on the boundary cycle itself.

// File: rtl/aba_pkg.sv
package aba_pkg;
  localparam int unsigned DEF_MECHS    = 3;
  localparam int unsigned DEF_POOL     = 8;
  localparam int unsigned DEF_CNT_W    = 7;
  localparam int unsigned DEF_INTERVAL = 256;

  // decoded action of one configuration write
  typedef enum logic [1:0] {
    CFG_IDLE    = 2'd0,
    CFG_LOAD    = 2'd1,
    CFG_RELEASE = 2'd2,
    CFG_REJECT  = 2'd3
  } cfg_act_e;
endpackage

// File: rtl/aba_interval_timer.sv
module aba_interval_timer #(
  parameter int unsigned INTERVAL = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == TW'(INTERVAL - 1));

  always_comb begin
    cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/aba_mech_monitor.sv
module aba_mech_monitor #(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned LA_MAX = 4,
  parameter int unsigned FS_THR = 4,
  parameter int unsigned LW     = $clog2(LA_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             miss_i,
  input  logic             hit_i,
  input  logic             stall_i,
  input  logic             full_i,
  output logic [CNT_W-1:0] miss_o,
  output logic [CNT_W-1:0] hit_o,
  output logic [CNT_W-1:0] stall_o,
  output logic [LW-1:0]    la_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] miss_q, hit_q, stall_q, fs_q;
  logic [CNT_W-1:0] miss_d, hit_d, stall_d, fs_d;
  logic [LW-1:0]    la_q, la_d;
  logic             cnt_en;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v,
                                            input logic ev, input logic clr);
    if (clr) return '0;
    if (ev && (v != CMAX)) return v + 1'b1;
    return v;
  endfunction

  assign cnt_en = tick_i | miss_i | hit_i | stall_i;

  always_comb begin
    miss_d  = bump(miss_q, miss_i, tick_i);
    hit_d   = bump(hit_q, hit_i, tick_i);
    stall_d = bump(stall_q, stall_i, tick_i);
    fs_d    = bump(fs_q, full_i & stall_i, tick_i);
  end

  // depth grows when full buffers still left the core stalling
  always_comb begin
    la_d = la_q;
    if ((fs_q >= CNT_W'(FS_THR)) && (la_q < LW'(LA_MAX)))
      la_d = la_q + 1'b1;
    else if ((stall_q == '0) && (la_q > LW'(1)))
      la_d = la_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q  <= '0;
      hit_q   <= '0;
      stall_q <= '0;
      fs_q    <= '0;
    end else if (cnt_en) begin
      miss_q  <= miss_d;
      hit_q   <= hit_d;
      stall_q <= stall_d;
      fs_q    <= fs_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     la_q <= LW'(1);
    else if (tick_i) la_q <= la_d;
  end

  assign miss_o  = miss_q;
  assign hit_o   = hit_q;
  assign stall_o = stall_q;
  assign la_o    = la_q;
endmodule

// File: rtl/aba_realloc_engine.sv
module aba_realloc_engine
  import aba_pkg::*;
#(
  parameter int unsigned NUM_MECH  = 3,
  parameter int unsigned POOL_BUFS = 8,
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned HYST      = 8,
  parameter int unsigned STALL_SH  = 1,
  parameter int unsigned AW        = $clog2(POOL_BUFS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic [NUM_MECH*CNT_W-1:0] hit_i,
  input  logic [NUM_MECH*CNT_W-1:0] stall_i,
  input  logic                      cfg_we_i,
  input  logic                      cfg_hold_i,
  input  logic [NUM_MECH*AW-1:0]    cfg_alloc_i,
  output logic [NUM_MECH*AW-1:0]    alloc_o
);
  localparam int unsigned SW     = CNT_W + 3;
  localparam int unsigned IW     = (NUM_MECH > 1) ? $clog2(NUM_MECH) : 1;
  localparam int unsigned BASE   = POOL_BUFS / NUM_MECH;
  localparam int unsigned EXTRA  = POOL_BUFS % NUM_MECH;

  logic [AW-1:0]        alloc_q [NUM_MECH];
  logic [AW-1:0]        alloc_d [NUM_MECH];
  logic [AW-1:0]        pend_q  [NUM_MECH];
  logic [AW-1:0]        pend_d  [NUM_MECH];
  logic                 pend_vld_q, pend_vld_d;
  logic                 manual_q, manual_d;
  logic signed [SW-1:0] score [NUM_MECH];
  logic signed [SW-1:0] gap;
  logic [IW-1:0]        recv, donor;
  logic                 donor_ok, do_move, cfg_ok, cfg_en;
  cfg_act_e             cfg_act;

  // benefit score: hits minus scaled stall penalty
  always_comb begin
    for (int m = 0; m < NUM_MECH; m++) begin
      score[m] = $signed(SW'(hit_i[m*CNT_W +: CNT_W]))
               - $signed(SW'(stall_i[m*CNT_W +: CNT_W] >> STALL_SH));
    end
  end

  always_comb begin
    recv     = '0;
    donor    = '0;
    donor_ok = 1'b0;
    for (int m = 1; m < NUM_MECH; m++) begin
      if (score[m] > score[recv]) recv = IW'(m);
    end
    for (int m = 0; m < NUM_MECH; m++) begin
      if ((alloc_q[m] > AW'(1)) && (!donor_ok || (score[m] < score[donor]))) begin
        donor    = IW'(m);
        donor_ok = 1'b1;
      end
    end
    gap     = score[recv] - score[donor];
    do_move = donor_ok && (recv != donor) && (gap > $signed(SW'(HYST)));
  end

  always_comb begin
    int sum;
    logic any_zero;
    sum      = 0;
    any_zero = 1'b0;
    for (int m = 0; m < NUM_MECH; m++) begin
      sum += int'(cfg_alloc_i[m*AW +: AW]);
      if (cfg_alloc_i[m*AW +: AW] == '0) any_zero = 1'b1;
    end
    cfg_ok = (sum == int'(POOL_BUFS)) && !any_zero;
    if (!cfg_we_i)        cfg_act = CFG_IDLE;
    else if (!cfg_hold_i) cfg_act = CFG_RELEASE;
    else if (cfg_ok)      cfg_act = CFG_LOAD;
    else                  cfg_act = CFG_REJECT;
  end

  always_comb begin
    for (int m = 0; m < NUM_MECH; m++) alloc_d[m] = alloc_q[m];
    if (pend_vld_q) begin
      for (int m = 0; m < NUM_MECH; m++) alloc_d[m] = pend_q[m];
    end else if (!manual_q && do_move) begin
      alloc_d[recv]  = alloc_q[recv] + 1'b1;
      alloc_d[donor] = alloc_q[donor] - 1'b1;
    end
  end

  always_comb begin
    for (int m = 0; m < NUM_MECH; m++) pend_d[m] = pend_q[m];
    pend_vld_d = tick_i ? 1'b0 : pend_vld_q;
    manual_d   = manual_q;
    case (cfg_act)
      CFG_LOAD: begin
        for (int m = 0; m < NUM_MECH; m++) pend_d[m] = cfg_alloc_i[m*AW +: AW];
        pend_vld_d = 1'b1;
        manual_d   = 1'b1;
      end
      CFG_RELEASE: begin
        pend_vld_d = 1'b0;
        manual_d   = 1'b0;
      end
      default: ;
    endcase
  end

  assign cfg_en = tick_i | cfg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int m = 0; m < NUM_MECH; m++)
        alloc_q[m] <= (m == 0) ? AW'(BASE + EXTRA) : AW'(BASE);
    end else if (tick_i) begin
      for (int m = 0; m < NUM_MECH; m++) alloc_q[m] <= alloc_d[m];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int m = 0; m < NUM_MECH; m++) pend_q[m] <= '0;
      pend_vld_q <= 1'b0;
      manual_q   <= 1'b0;
    end else if (cfg_en) begin
      for (int m = 0; m < NUM_MECH; m++) pend_q[m] <= pend_d[m];
      pend_vld_q <= pend_vld_d;
      manual_q   <= manual_d;
    end
  end

  always_comb begin
    for (int m = 0; m < NUM_MECH; m++) alloc_o[m*AW +: AW] = alloc_q[m];
  end
endmodule

// File: rtl/aba_buffer_allocator.sv
module aba_buffer_allocator
  import aba_pkg::*;
#(
  parameter int unsigned NUM_MECH  = DEF_MECHS,
  parameter int unsigned POOL_BUFS = DEF_POOL,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned INTERVAL  = DEF_INTERVAL,
  parameter int unsigned HYST      = 8,
  parameter int unsigned STALL_SH  = 1,
  parameter int unsigned LA_MAX    = 4,
  parameter int unsigned FS_THR    = 4,
  parameter int unsigned AW        = $clog2(POOL_BUFS + 1),
  parameter int unsigned IW        = (NUM_MECH > 1) ? $clog2(NUM_MECH) : 1,
  parameter int unsigned LW        = $clog2(LA_MAX + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_MECH-1:0]       ev_miss_i,
  input  logic [NUM_MECH-1:0]       ev_hit_i,
  input  logic [NUM_MECH-1:0]       ev_stall_i,
  input  logic [NUM_MECH-1:0]       ev_full_i,
  input  logic                      cfg_we_i,
  input  logic                      cfg_hold_i,
  input  logic [NUM_MECH*AW-1:0]    cfg_alloc_i,
  output logic                      interval_end_o,
  output logic [NUM_MECH*AW-1:0]    alloc_cnt_o,
  output logic [POOL_BUFS*IW-1:0]   own_map_o,
  output logic [NUM_MECH*LW-1:0]    lookahead_o,
  output logic [NUM_MECH*CNT_W-1:0] rd_miss_o,
  output logic [NUM_MECH*CNT_W-1:0] rd_hit_o,
  output logic [NUM_MECH*CNT_W-1:0] rd_stall_o
);
  logic [1:0]                rst_sync_q;
  logic                      rst_n_int;
  logic                      tick;
  logic [NUM_MECH*CNT_W-1:0] miss_live, hit_live, stall_live;
  logic [NUM_MECH*CNT_W-1:0] rd_miss_q, rd_hit_q, rd_stall_q;

  // assert asynchronously, release after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  aba_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .tick_o (tick)
  );

  for (genvar g = 0; g < NUM_MECH; g++) begin : g_mon
    aba_mech_monitor #(
      .CNT_W (CNT_W), .LA_MAX (LA_MAX), .FS_THR (FS_THR), .LW (LW)
    ) u_mon (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_int),
      .tick_i  (tick),
      .miss_i  (ev_miss_i[g]),
      .hit_i   (ev_hit_i[g]),
      .stall_i (ev_stall_i[g]),
      .full_i  (ev_full_i[g]),
      .miss_o  (miss_live[g*CNT_W +: CNT_W]),
      .hit_o   (hit_live[g*CNT_W +: CNT_W]),
      .stall_o (stall_live[g*CNT_W +: CNT_W]),
      .la_o    (lookahead_o[g*LW +: LW])
    );
  end

  aba_realloc_engine #(
    .NUM_MECH (NUM_MECH), .POOL_BUFS (POOL_BUFS), .CNT_W (CNT_W),
    .HYST (HYST), .STALL_SH (STALL_SH), .AW (AW)
  ) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .tick_i      (tick),
    .hit_i       (hit_live),
    .stall_i     (stall_live),
    .cfg_we_i    (cfg_we_i),
    .cfg_hold_i  (cfg_hold_i),
    .cfg_alloc_i (cfg_alloc_i),
    .alloc_o     (alloc_cnt_o)
  );

  // contiguous ownership: prefix sums of the counts mark the cut points
  always_comb begin
    for (int b = 0; b < POOL_BUFS; b++) begin
      int cum;
      int owner;
      cum   = 0;
      owner = 0;
      for (int m = 0; m < NUM_MECH - 1; m++) begin
        cum += int'(alloc_cnt_o[m*AW +: AW]);
        if (b >= cum) owner = m + 1;
      end
      own_map_o[b*IW +: IW] = IW'(owner);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rd_miss_q  <= '0;
      rd_hit_q   <= '0;
      rd_stall_q <= '0;
    end else if (tick) begin
      rd_miss_q  <= miss_live;
      rd_hit_q   <= hit_live;
      rd_stall_q <= stall_live;
    end
  end

  assign interval_end_o = tick;
  assign rd_miss_o      = rd_miss_q;
  assign rd_hit_o       = rd_hit_q;
  assign rd_stall_o     = rd_stall_q;
endmodule

// File: rtl/aba_alloc_checker.sv
module aba_alloc_checker #(
  parameter int unsigned NUM_MECH  = 3,
  parameter int unsigned POOL_BUFS = 8,
  parameter int unsigned LA_MAX    = 4,
  parameter int unsigned AW        = $clog2(POOL_BUFS + 1),
  parameter int unsigned IW        = (NUM_MECH > 1) ? $clog2(NUM_MECH) : 1,
  parameter int unsigned LW        = $clog2(LA_MAX + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic [NUM_MECH*AW-1:0]  alloc_i,
  input logic [POOL_BUFS*IW-1:0] own_i,
  input logic [NUM_MECH*LW-1:0]  la_i
);
  int   alloc_sum;
  logic floor_ok, la_ok, own_ok;

  always_comb begin
    alloc_sum = 0;
    floor_ok  = 1'b1;
    la_ok     = 1'b1;
    own_ok    = 1'b1;
    for (int m = 0; m < NUM_MECH; m++) begin
      int owned;
      owned = 0;
      alloc_sum += int'(alloc_i[m*AW +: AW]);
      if (alloc_i[m*AW +: AW] == '0) floor_ok = 1'b0;
      if ((la_i[m*LW +: LW] == '0) || (la_i[m*LW +: LW] > LW'(LA_MAX))) la_ok = 1'b0;
      for (int b = 0; b < POOL_BUFS; b++)
        if (own_i[b*IW +: IW] == IW'(m)) owned++;
      if (owned != int'(alloc_i[m*AW +: AW])) own_ok = 1'b0;
    end
  end

  // R3
  pool_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_sum == int'(POOL_BUFS));
  // R3
  floor_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    floor_ok);
  // R4
  own_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_ok);
  // R5
  alloc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(alloc_i));
  // R8
  la_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    la_ok);
  // R8
  la_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(la_i));
endmodule

bind aba_buffer_allocator aba_alloc_checker #(
  .NUM_MECH (NUM_MECH), .POOL_BUFS (POOL_BUFS), .LA_MAX (LA_MAX)
) u_aba_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (interval_end_o),
  .alloc_i (alloc_cnt_o),
  .own_i   (own_map_o),
  .la_i    (lookahead_o)
);

// File: tb/test_aba_buffer_allocator.sv
`timescale 1ns/1ps
module test_aba_buffer_allocator;
  localparam int M = 3, POOL = 8, AW = 4, IW = 2, CW = 7, LW = 3;
  localparam int INTERVAL = 256, HYST = 8, LA_MAX = 4, FS_THR = 4, CMAX = 127;

  logic clk = 1'b0;
  logic rst_ni;
  logic [M-1:0] ev_miss, ev_hit, ev_stall, ev_full;
  logic cfg_we, cfg_hold;
  logic [M*AW-1:0] cfg_alloc;
  logic interval_end;
  logic [M*AW-1:0] alloc_cnt;
  logic [POOL*IW-1:0] own_map;
  logic [M*LW-1:0] lookahead;
  logic [M*CW-1:0] rd_miss, rd_hit, rd_stall;

  always #5 clk = ~clk;

  aba_buffer_allocator i_aba_buffer_allocator (
    .clk_i(clk), .rst_ni(rst_ni),
    .ev_miss_i(ev_miss), .ev_hit_i(ev_hit), .ev_stall_i(ev_stall), .ev_full_i(ev_full),
    .cfg_we_i(cfg_we), .cfg_hold_i(cfg_hold), .cfg_alloc_i(cfg_alloc),
    .interval_end_o(interval_end), .alloc_cnt_o(alloc_cnt), .own_map_o(own_map),
    .lookahead_o(lookahead), .rd_miss_o(rd_miss), .rd_hit_o(rd_hit), .rd_stall_o(rd_stall)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_alloc[M], m_la[M], m_miss[M], m_hit[M], m_stall[M], m_fs[M];
  int r_miss[M], r_hit[M], r_stall[M], m_pend[M];
  int mcnt, m_manual, m_pvld;

  // stimulus knobs (percent)
  int pm[M], ph[M], ps[M], pf[M];
  int rand_cfg_pct = 0;
  bit req_we = 0, req_hold = 0;
  int req_val[M];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int score_of(input int h, input int s);
    return h - (s >> 1);
  endfunction

  function automatic logic [63:0] pack_alloc(input int a0, input int a1, input int a2);
    logic [63:0] v = '0;
    v[3:0] = a0[3:0]; v[7:4] = a1[3:0]; v[11:8] = a2[3:0];
    return v;
  endfunction

  task automatic compare_all();
    logic [63:0] ea, eo, el, erm, erh, ers;
    int sum = 0, cum;
    bit floor = 1;
    ea = '0; eo = '0; el = '0; erm = '0; erh = '0; ers = '0;
    for (int m = 0; m < M; m++) begin
      ea[m*AW +: AW] = m_alloc[m][AW-1:0];
      el[m*LW +: LW] = m_la[m][LW-1:0];
      erm[m*CW +: CW] = r_miss[m][CW-1:0];
      erh[m*CW +: CW] = r_hit[m][CW-1:0];
      ers[m*CW +: CW] = r_stall[m][CW-1:0];
      sum += int'(alloc_cnt[m*AW +: AW]);
      if (alloc_cnt[m*AW +: AW] == 0) floor = 0;
    end
    for (int b = 0; b < POOL; b++) begin
      int own = 0;
      cum = 0;
      for (int m = 0; m < M - 1; m++) begin
        cum += m_alloc[m];
        if (b >= cum) own = m + 1;
      end
      eo[b*IW +: IW] = own[IW-1:0];
    end
    check("R5 alloc", 64'(alloc_cnt), ea);
    check("R3 sum/floor", {62'd0, floor, sum == POOL}, 64'd3);
    check("R4 own_map", 64'(own_map), eo);
    check("R8 lookahead", 64'(lookahead), el);
    check("R7 rd_miss", 64'(rd_miss), erm);
    check("R7 rd_hit", 64'(rd_hit), erh);
    check("R7 rd_stall", 64'(rd_stall), ers);
    check("R2 interval_end", 64'(interval_end), 64'(mcnt == INTERVAL - 1));
  endtask

  task automatic drive();
    for (int m = 0; m < M; m++) begin
      ev_miss[m]  = ($urandom % 100) < pm[m];
      ev_hit[m]   = ($urandom % 100) < ph[m];
      ev_stall[m] = ($urandom % 100) < ps[m];
      ev_full[m]  = ($urandom % 100) < pf[m];
    end
    cfg_we = 0; cfg_hold = 0; cfg_alloc = '0;
    if (req_we) begin
      cfg_we = 1; cfg_hold = req_hold;
      for (int m = 0; m < M; m++) cfg_alloc[m*AW +: AW] = req_val[m][AW-1:0];
      req_we = 0;
    end else if (($urandom % 1000) < rand_cfg_pct) begin
      cfg_we = 1; cfg_hold = ($urandom % 4) != 0;
      for (int m = 0; m < M; m++) cfg_alloc[m*AW +: AW] = AW'($urandom % 6);
    end
  endtask

  task automatic model_step();
    if (mcnt == INTERVAL - 1) begin
      int s[M];
      int recv = 0, donor = 0;
      bit dok = 0;
      for (int m = 0; m < M; m++) s[m] = score_of(m_hit[m], m_stall[m]);
      for (int m = 1; m < M; m++) if (s[m] > s[recv]) recv = m;
      for (int m = 0; m < M; m++)
        if (m_alloc[m] > 1 && (!dok || s[m] < s[donor])) begin donor = m; dok = 1; end
      if (m_pvld) begin
        for (int m = 0; m < M; m++) m_alloc[m] = m_pend[m];
      end else if (!m_manual && dok && recv != donor && (s[recv] - s[donor]) > HYST) begin
        m_alloc[recv]++; m_alloc[donor]--;
      end
      m_pvld = 0;
      for (int m = 0; m < M; m++) begin
        if (m_fs[m] >= FS_THR && m_la[m] < LA_MAX) m_la[m]++;
        else if (m_stall[m] == 0 && m_la[m] > 1) m_la[m]--;
        r_miss[m] = m_miss[m]; r_hit[m] = m_hit[m]; r_stall[m] = m_stall[m];
        m_miss[m] = 0; m_hit[m] = 0; m_stall[m] = 0; m_fs[m] = 0;
      end
      mcnt = 0;
    end else begin
      for (int m = 0; m < M; m++) begin
        if (ev_miss[m] && m_miss[m] < CMAX) m_miss[m]++;
        if (ev_hit[m] && m_hit[m] < CMAX) m_hit[m]++;
        if (ev_stall[m] && m_stall[m] < CMAX) m_stall[m]++;
        if (ev_full[m] && ev_stall[m] && m_fs[m] < CMAX) m_fs[m]++;
      end
      mcnt++;
    end
    if (cfg_we) begin
      if (cfg_hold) begin
        int sum = 0;
        bit zero = 0;
        for (int m = 0; m < M; m++) begin
          sum += int'(cfg_alloc[m*AW +: AW]);
          if (cfg_alloc[m*AW +: AW] == 0) zero = 1;
        end
        if (sum == POOL && !zero) begin
          for (int m = 0; m < M; m++) m_pend[m] = int'(cfg_alloc[m*AW +: AW]);
          m_pvld = 1; m_manual = 1;
        end
      end else begin
        m_manual = 0; m_pvld = 0;
      end
    end
  endtask

  task automatic cycle();
    compare_all();
    drive();
    model_step();
    @(negedge clk);
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic run_intervals(input int n);
    int k = 0;
    while (k < n) begin
      if (mcnt == INTERVAL - 1) k++;
      cycle();
    end
  endtask

  task automatic run_to_pre_tick();
    while (mcnt != INTERVAL - 1) cycle();
  endtask

  task automatic set_probs(input int a, input int b, input int c, input int d);
    for (int m = 0; m < M; m++) begin pm[m] = a; ph[m] = b; ps[m] = c; pf[m] = d; end
  endtask

  task automatic request(input bit hold, input int a0, input int a1, input int a2);
    req_we = 1; req_hold = hold; req_val[0] = a0; req_val[1] = a1; req_val[2] = a2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 0; ev_miss = 0; ev_hit = 0; ev_stall = 0; ev_full = 0;
    cfg_we = 0; cfg_hold = 0; cfg_alloc = '0;
    for (int m = 0; m < M; m++) begin
      m_alloc[m] = (m == 0) ? 4 : 2; m_la[m] = 1;
      m_miss[m] = 0; m_hit[m] = 0; m_stall[m] = 0; m_fs[m] = 0;
      r_miss[m] = 0; r_hit[m] = 0; r_stall[m] = 0; m_pend[m] = 0;
    end
    mcnt = 0; m_manual = 0; m_pvld = 0;
    set_probs(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset alloc", 64'(alloc_cnt), pack_alloc(4, 2, 2));
    check("R1 reset own_map", 64'(own_map), 64'h0000_0000_0000_A500);
    check("R1 reset lookahead", 64'(lookahead), 64'o111);
    check("R1 reset readback", 64'(rd_hit | rd_miss | rd_stall), 64'd0);
    check("R1 reset interval_end", 64'(interval_end), 64'd0);
    rst_ni = 1;
    @(negedge clk); @(negedge clk);

    // balanced random traffic
    set_probs(30, 30, 30, 30);
    run_intervals(4);

    // R5: drain mechanisms 0 and 1 toward the floor
    for (int m = 0; m < M; m++) begin pm[m] = 20; pf[m] = 0; end
    ph[0] = 0; ph[1] = 0; ph[2] = 100;
    ps[0] = 50; ps[1] = 50; ps[2] = 0;
    run_intervals(6);
    check("R5 drained split", 64'(alloc_cnt), pack_alloc(1, 1, 6));
    check("R3 floor held at receiver exhaustion", 64'(alloc_cnt[3:0] == 1 && alloc_cnt[7:4] == 1), 64'd1);

    // R6: every event every cycle saturates counters
    set_probs(100, 100, 100, 100);
    run_intervals(1);
    check("R6 saturated miss", 64'(rd_miss), {43'd0, 7'd127, 7'd127, 7'd127});
    check("R6 saturated hit", 64'(rd_hit), {43'd0, 7'd127, 7'd127, 7'd127});

    // R8: lookahead climbs to its ceiling then decays when quiet
    set_probs(10, 10, 100, 100);
    run_intervals(4);
    check("R8 lookahead ceiling", 64'(lookahead), 64'o444);
    set_probs(0, 0, 0, 0);
    run_intervals(4);
    check("R8 lookahead floor", 64'(lookahead), 64'o111);

    // R9: manual split applies at next boundary only
    run_cycles(100);
    request(1, 2, 3, 3);
    run_to_pre_tick();
    check("R9 before boundary", 64'(alloc_cnt), pack_alloc(1, 1, 6));
    run_intervals(1);
    check("R9 applied at boundary", 64'(alloc_cnt), pack_alloc(2, 3, 3));
    ph[0] = 0; ph[1] = 0; ph[2] = 100;
    ps[0] = 80; ps[1] = 20; ps[2] = 0;
    run_intervals(2);
    check("R9 auto frozen", 64'(alloc_cnt), pack_alloc(2, 3, 3));
    request(1, 0, 4, 4);
    run_cycles(3);
    request(1, 3, 3, 3);
    run_intervals(1);
    check("R9 invalid writes ignored", 64'(alloc_cnt), pack_alloc(2, 3, 3));

    // R10: release resumes automatic moves
    request(0, 0, 0, 0);
    run_intervals(1);
    check("R10 auto resumed", 64'(alloc_cnt), pack_alloc(1, 3, 4));

    // mixed random traffic with random configuration writes
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < M; m++) begin
        pm[m] = $urandom % 101; ph[m] = $urandom % 101;
        ps[m] = $urandom % 101; pf[m] = $urandom % 101;
      end
      rand_cfg_pct = 3;
      run_intervals(1);
    end
    rand_cfg_pct = 0;
    request(0, 0, 0, 0);
    run_intervals(2);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule